// File: doc/BRIEF.md
# Sequential Restoring Integer Divider

This block divides one unsigned operand by another over several clock cycles. A caller presents a dividend and a divisor and pulses `start`. The block then produces one quotient bit per cycle. A single packed working register carries both results: its upper half is the running remainder and its lower half fills with quotient bits from the right. Each cycle the register shifts left by one place, and the divisor is trial-subtracted from the upper half. The borrow out of that subtraction decides whether the difference is kept (quotient bit 1) or the shifted value is restored (quotient bit 0).

When the last bit is settled, `valid` pulses for one cycle. The results stay on the outputs until the next accepted start. The controller has two states, idle and running, so the block cannot queue a second request while one is in flight. A zero divisor raises no error and gives a fixed, defined answer.

Top module: `seq_restoring_divider`

## Requirements
- R1: While `rst` is high, and in the first cycle after it falls, `valid` is 0 and `quotient` and `remainder` are 0. A reset asserted in the middle of a division abandons it.
- R2: A `start` pulse sampled high while idle captures `dividend` and `divisor` on that rising edge and begins a division.
- R3: `valid` goes high on the W-th rising edge after the edge that accepted `start`, where W is the operand width (4 by default). That is one cycle per quotient bit.
- R4: `valid` is high for exactly one cycle per division.
- R5: With a nonzero divisor, `quotient` equals the integer quotient of the captured operands while `valid` is high.
- R6: With a nonzero divisor, `remainder` equals the dividend modulo the divisor while `valid` is high, and it is smaller than the divisor.
- R7: A `start` sampled while a division is running is ignored. The running result, its timing and the captured divisor are unchanged, and no extra division follows.
- R8: With a zero divisor, the block still finishes after W cycles, with `quotient` all ones and `remainder` equal to the dividend.
- R9: A `start` sampled in the cycle where `valid` is high is accepted, so divisions can run back to back with no dead cycle.
- R10: While idle and without a new start, `quotient` and `remainder` hold their last values, whatever the operand inputs do.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Request a division; honoured only when idle |
| dividend | input | W | Unsigned dividend, sampled on the accepting edge |
| divisor | input | W | Unsigned divisor, sampled on the accepting edge |
| quotient | output | W | Quotient, lower half of the working register |
| remainder | output | W | Remainder, upper half of the working register |
| valid | output | 1 | One-cycle pulse marking a finished division |

## Verification
The completion pulse of one division and the acceptance of the next request can fall in the same cycle. The bench provokes this by raising `start` with new operands at the very sample where it sees `valid` high. It then judges that the first result was correct at that moment, that `valid` drops the next cycle, and that the second result arrives exactly W cycles after the overlap edge. A second overlap, a request arriving mid-run, is judged by checking that the first operands' result and timing are unchanged and that no extra `valid` pulse follows.

// File: rtl/div_pkg.sv
package div_pkg;

    // Default operand width shared by the divider and its checker
    localparam int unsigned DIV_W_DEF = 4;

    // Controller state: waiting for a request, or iterating
    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_RUN  = 1'b1
    } div_state_e;

    // Per-cycle commands from the controller to the datapath
    typedef struct packed {
        logic load;     // capture operands into the working register
        logic iterate;  // apply one shift-and-trial step
    } div_ctrl_t;

endpackage

// File: rtl/div_step.sv
module div_step #(
    parameter int unsigned W = div_pkg::DIV_W_DEF
) (
    input  logic [2*W-1:0] work_in,
    input  logic [W-1:0]   divisor,
    output logic [2*W-1:0] work_out
);
    localparam int unsigned WW = 2 * W;

    logic [WW-1:0] shifted;
    logic [W:0]    trial;
    logic          borrow;

    always_comb begin
        shifted = {work_in[WW-2:0], 1'b0};
        trial   = {1'b0, shifted[WW-1:W]} - {1'b0, divisor};
        borrow  = trial[W];
        if (borrow) begin
            // restore: keep shifted partial remainder, quotient bit 0
            work_out = {shifted[WW-1:W], shifted[W-1:1], 1'b0};
        end else begin
            // commit: take the difference, quotient bit 1
            work_out = {trial[W-1:0], shifted[W-1:1], 1'b1};
        end
    end
endmodule

// File: rtl/div_seq_ctrl.sv
module div_seq_ctrl #(
    parameter int unsigned W = div_pkg::DIV_W_DEF
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               start,
    output div_pkg::div_ctrl_t ctrl,
    output logic               busy,
    output logic               valid
);
    localparam int unsigned CW   = (W > 1) ? $clog2(W) : 1;
    localparam logic [CW-1:0] LAST = CW'(W - 1);

    div_pkg::div_state_e state_q;
    logic [CW-1:0]       count_q;
    logic                finish;

    always_comb begin
        ctrl.load    = (state_q == div_pkg::ST_IDLE) && start;
        ctrl.iterate = (state_q == div_pkg::ST_RUN);
        finish       = ctrl.iterate && (count_q == LAST);
        busy         = (state_q == div_pkg::ST_RUN);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= div_pkg::ST_IDLE;
            count_q <= '0;
            valid   <= 1'b0;
        end else begin
            valid <= finish;
            case (state_q)
                div_pkg::ST_IDLE: begin
                    count_q <= '0;
                    if (start) state_q <= div_pkg::ST_RUN;
                end
                div_pkg::ST_RUN: begin
                    if (finish) begin
                        state_q <= div_pkg::ST_IDLE;
                        count_q <= '0;
                    end else begin
                        count_q <= count_q + 1'b1;
                    end
                end
                default: state_q <= div_pkg::ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/seq_restoring_divider.sv
module seq_restoring_divider #(
    parameter int unsigned W = div_pkg::DIV_W_DEF
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         start,
    input  logic [W-1:0] dividend,
    input  logic [W-1:0] divisor,
    output logic [W-1:0] quotient,
    output logic [W-1:0] remainder,
    output logic         valid
);
    localparam int unsigned WW = 2 * W;

    div_pkg::div_ctrl_t ctrl;
    logic               busy;
    logic [WW-1:0]      work_q;
    logic [WW-1:0]      work_nxt;
    logic [W-1:0]       div_q;

    div_seq_ctrl #(.W(W)) ctrl_i (
        .clk   (clk),
        .rst   (rst),
        .start (start),
        .ctrl  (ctrl),
        .busy  (busy),
        .valid (valid)
    );

    div_step #(.W(W)) step_i (
        .work_in  (work_q),
        .divisor  (div_q),
        .work_out (work_nxt)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            work_q <= '0;
            div_q  <= '0;
        end else if (ctrl.load) begin
            work_q <= {{W{1'b0}}, dividend};
            div_q  <= divisor;
        end else if (ctrl.iterate) begin
            work_q <= work_nxt;
        end
    end

    assign quotient  = work_q[W-1:0];
    assign remainder = work_q[WW-1:W];
endmodule

// File: rtl/seq_restoring_divider_chk.sv
module seq_restoring_divider_chk #(
    parameter int unsigned W = div_pkg::DIV_W_DEF
) (
    input logic           clk,
    input logic           rst,
    input logic           start,
    input logic [W-1:0]   dividend,
    input logic [W-1:0]   divisor,
    input logic [W-1:0]   quotient,
    input logic [W-1:0]   remainder,
    input logic           valid,
    input logic           busy,
    input logic [W-1:0]   div_q,
    input logic [2*W-1:0] work_q
);
    logic [W-1:0]   cap_a;
    logic [W-1:0]   cap_b;
    logic [2*W-1:0] recon;

    // checker's own copy of the accepted operands
    always_ff @(posedge clk) begin
        if (rst) begin
            cap_a <= '0;
            cap_b <= '0;
        end else if (start && !busy) begin
            cap_a <= dividend;
            cap_b <= divisor;
        end
    end

    assign recon = {{W{1'b0}}, quotient} * {{W{1'b0}}, cap_b} + {{W{1'b0}}, remainder};

    assert_reset_clear_R1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!valid && !busy && work_q == '0));

    assert_valid_after_run_R3: assert property (@(posedge clk) disable iff (rst)
        valid |-> (!busy && $past(busy)));

    assert_valid_pulse_R4: assert property (@(posedge clk) disable iff (rst)
        valid |=> !valid);

    assert_quotient_R5: assert property (@(posedge clk) disable iff (rst)
        (valid && cap_b != '0) |-> (recon == {{W{1'b0}}, cap_a}));

    assert_remainder_R6: assert property (@(posedge clk) disable iff (rst)
        (valid && cap_b != '0) |-> (remainder < cap_b));

    assert_ignore_start_R7: assert property (@(posedge clk) disable iff (rst)
        (busy && start) |=> $stable(div_q));

    assert_div_zero_R8: assert property (@(posedge clk) disable iff (rst)
        (valid && cap_b == '0) |-> (quotient == '1 && remainder == cap_a));

    assert_hold_R10: assert property (@(posedge clk) disable iff (rst)
        (!busy && !start) |=> $stable(work_q));
endmodule

bind seq_restoring_divider seq_restoring_divider_chk #(.W(W)) chk_i (
    .clk       (clk),
    .rst       (rst),
    .start     (start),
    .dividend  (dividend),
    .divisor   (divisor),
    .quotient  (quotient),
    .remainder (remainder),
    .valid     (valid),
    .busy      (busy),
    .div_q     (div_q),
    .work_q    (work_q)
);

// File: tb/seq_restoring_divider_tb_top.sv
module seq_restoring_divider_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int W = 4;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         start = 1'b0;
    logic [W-1:0] dividend = '0;
    logic [W-1:0] divisor = '0;
    logic [W-1:0] quotient;
    logic [W-1:0] remainder;
    logic         valid;

    int checks = 0;
    int fails  = 0;

    // {dividend, divisor, quotient, remainder}
    localparam logic [15:0] VEC [8] = '{
        {4'd15, 4'd8,  4'd1,  4'd7},
        {4'd0,  4'd3,  4'd0,  4'd0},
        {4'd9,  4'd3,  4'd3,  4'd0},
        {4'd14, 4'd5,  4'd2,  4'd4},
        {4'd15, 4'd1,  4'd15, 4'd0},
        {4'd1,  4'd15, 4'd0,  4'd1},
        {4'd7,  4'd0,  4'd15, 4'd7},
        {4'd15, 4'd15, 4'd1,  4'd0}
    };

    always #(CLK_PERIOD/2) clk = ~clk;

    seq_restoring_divider #(.W(W)) dut_i (
        .clk(clk), .rst(rst), .start(start), .dividend(dividend),
        .divisor(divisor), .quotient(quotient), .remainder(remainder),
        .valid(valid)
    );

    task automatic check_eq(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", checks - fails, checks);
    endtask

    // Launch one division and wait for valid; returns cycles to valid
    task automatic run_div(input logic [W-1:0] a, input logic [W-1:0] b,
                           output logic [W-1:0] q, output logic [W-1:0] r,
                           output int lat);
        @(negedge clk);
        start = 1'b1; dividend = a; divisor = b;
        @(negedge clk);
        start = 1'b0; lat = 0;
        while (!valid && lat < 20) begin
            @(negedge clk);
            lat++;
        end
        q = quotient;
        r = remainder;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog expired actual=running expected=finished");
        summary();
        $finish;
    end

    initial begin
        logic [W-1:0] q, r;
        int lat;

        // R1: reset state
        repeat (3) @(negedge clk);
        check_eq("R1 valid in reset", int'(valid), 0);
        check_eq("R1 quotient in reset", int'(quotient), 0);
        check_eq("R1 remainder in reset", int'(remainder), 0);
        rst = 1'b0;
        @(negedge clk);
        check_eq("R1 valid after reset", int'(valid), 0);

        // Vector table: R2 R3 R5 R6 R8
        for (int i = 0; i < 8; i++) begin
            run_div(VEC[i][15:12], VEC[i][11:8], q, r, lat);
            check_eq("R3 latency", lat, W);
            check_eq("R5 quotient vec", int'(q), int'(VEC[i][7:4]));
            check_eq("R6 remainder vec", int'(r), int'(VEC[i][3:0]));
            @(negedge clk);
            check_eq("R4 valid drops", int'(valid), 0);
        end

        // Exhaustive sweep, expected values from integer arithmetic (R2 R5 R6 R8)
        for (int a = 0; a < 16; a++) begin
            for (int b = 0; b < 16; b++) begin
                run_div(W'(a), W'(b), q, r, lat);
                if (b == 0) begin
                    check_eq("R8 zero divisor quotient", int'(q), 15);
                    check_eq("R8 zero divisor remainder", int'(r), a);
                end else begin
                    check_eq("R5 quotient", int'(q), a / b);
                    check_eq("R6 remainder", int'(r), a % b);
                end
            end
        end

        // R7: start during a running division is ignored
        @(negedge clk);
        start = 1'b1; dividend = 4'd13; divisor = 4'd4;
        @(negedge clk);
        start = 1'b0; lat = 0;
        @(negedge clk); lat++;
        start = 1'b1; dividend = 4'd2; divisor = 4'd1;
        @(negedge clk); lat++;
        start = 1'b0;
        while (!valid && lat < 20) begin
            @(negedge clk);
            lat++;
        end
        check_eq("R7 latency unchanged", lat, W);
        check_eq("R7 quotient of first operands", int'(quotient), 3);
        check_eq("R7 remainder of first operands", int'(remainder), 1);
        begin
            int extra = 0;
            for (int k = 0; k < 8; k++) begin
                @(negedge clk);
                if (valid) extra++;
            end
            check_eq("R7 no queued division", extra, 0);
        end

        // R9: start in the valid cycle is accepted (back to back)
        run_div(4'd11, 4'd2, q, r, lat);
        check_eq("R9 first quotient", int'(q), 5);
        check_eq("R9 first remainder", int'(r), 1);
        start = 1'b1; dividend = 4'd12; divisor = 4'd7;
        @(negedge clk);
        start = 1'b0; lat = 0;
        check_eq("R4 valid low after overlap", int'(valid), 0);
        while (!valid && lat < 20) begin
            @(negedge clk);
            lat++;
        end
        check_eq("R9 second latency", lat, W);
        check_eq("R9 second quotient", int'(quotient), 1);
        check_eq("R9 second remainder", int'(remainder), 5);

        // R10: results hold while idle with changing inputs
        repeat (2) @(negedge clk);
        dividend = 4'd3; divisor = 4'd9;
        repeat (3) @(negedge clk);
        check_eq("R10 quotient held", int'(quotient), 1);
        check_eq("R10 remainder held", int'(remainder), 5);
        check_eq("R10 no valid", int'(valid), 0);

        // R1: reset in the middle of a division
        @(negedge clk);
        start = 1'b1; dividend = 4'd15; divisor = 4'd2;
        @(negedge clk);
        start = 1'b0;
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        check_eq("R1 mid-run reset valid", int'(valid), 0);
        check_eq("R1 mid-run reset quotient", int'(quotient), 0);
        check_eq("R1 mid-run reset remainder", int'(remainder), 0);
        rst = 1'b0;
        begin
            int seen = 0;
            for (int k = 0; k < 8; k++) begin
                @(negedge clk);
                if (valid) seen++;
            end
            check_eq("R1 abandoned run gives no valid", seen, 0);
        end

        summary();
        $finish;
    end
endmodule